// File: doc/BRIEF.md
# Flash Control Register Interlock

This block is the register front end that selects the operating mode of an on-chip flash array. A byte-wide peripheral bus reaches seven 8-bit registers: a mode control register, a read-only mode status register, two erase-block select registers, a power configuration register, a system control register and a RAM emulation register. Access to the flash-side registers is gated by an access-enable bit in the system control register, by a chip-mode input that says whether flash is usable at all, and by an external write-protect pin.

Program and erase can only be reached through a fixed order: the software write-enable bit first, then a setup bit, then the execute bit. The verify modes need the software write-enable bit first and then the verify bit. The two paths exclude each other. The block decodes the resulting mode into a one-hot code for the flash sequencer, and presents the erase-block selection and the power configuration as outputs. Reset, either standby input, the pin going low or software write-enable being cleared all take the mode back to idle.

Top module: `flash_ctl_interlock`

## Requirements
- R1: After reset the mode control register (0xFFA8) reads 0x80 with `prog_pin` high and 0x00 with it low. Bit 7 always shows the live pin level and cannot be written. `mode_code` is idle.
- R2: The system control register (0xFDB4) and the RAM emulation register (0xFEDB) can be read and written whatever the access-enable bit and `flash_en` are. Bit 0 of the system control register is the access-enable bit.
- R3: While access-enable is 0 or `flash_en` is 0, reads of 0xFFA8 to 0xFFAC return 0x00 and writes to them have no effect.
- R4: While `prog_pin` is low, writes to 0xFFA8 to 0xFFAC have no effect.
- R5: The erase-block registers (0xFFAA is the low byte and 0xFFAB the high byte of `erase_sel`) and the power register (0xFFAC, driving `pwr_cfg`) are cleared one clock after the pin is low or software write-enable is clear. In that state, writes to them have no effect.
- R6: The mode register layout, from bit 7 down, is: pin, software write-enable, erase-setup, program-setup, erase-verify, program-verify, erase, program. A mode bit takes a write only if software write-enable was already 1 before that write. The program bit takes a write only if program-setup was already 1 and stays 1.
- R7: The erase bit takes a write only if erase-setup was already 1 and stays 1. Erase-setup itself needs software write-enable set beforehand.
- R8: The program-verify and erase-verify bits take a write only if software write-enable was already set.
- R9: A setup bit is ignored while the other path has its setup bit or its execute bit set. If both setup bits are written from idle, only program-setup is kept.
- R10: Writing software write-enable to 0 clears every other mode bit on the same edge. With the pin low, all mode bits clear on the next edge and `mode_code` shows idle at once.
- R11: `mode_code` is one-hot, with bit 0 for idle, 1 for program, 2 for erase, 3 for program-verify and 4 for erase-verify. The priority is program, then erase, then program-verify, then erase-verify. The status register (0xFFA9) reads {3'b000, `mode_code`} and ignores writes.
- R12: A high level on `hw_stby` or `sw_stby` at a clock edge clears all stored mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hw_stby | input | 1 | Hardware standby, clears mode bits |
| sw_stby | input | 1 | Software standby, clears mode bits |
| prog_pin | input | 1 | External flash write-protect pin, high permits writes |
| flash_en | input | 1 | Chip mode has flash enabled |
| bus_addr | input | 16 | Register byte address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| mode_code | output | 5 | One-hot operating mode |
| erase_sel | output | 16 | Erase-block selection |
| pwr_cfg | output | 8 | Power configuration |

## Verification
A write lands on the clock edge where the strobe is sampled. Read data and `mode_code` are combinational from the registers, so they are valid by the following falling edge. The erase-block and power registers clear one edge later than the write that drops software write-enable, because they look at the registered enable bit. The bench drives on falling edges and checks one full cycle after each write task returns, which puts every check past the edge that carries that dependent clear. The pin-low idle code is also checked just after the pin falls, before any edge.

// File: rtl/flash_ilk_pkg.sv
package flash_ilk_pkg;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int NUM_AUX = 3;
  localparam int MODE_W = 5;

  localparam logic [AW-1:0] A_CTL  = 16'hFFA8;
  localparam logic [AW-1:0] A_STAT = 16'hFFA9;
  localparam logic [AW-1:0] A_AUX0 = 16'hFFAA;
  localparam logic [AW-1:0] A_EMU  = 16'hFEDB;
  localparam logic [AW-1:0] A_SYS  = 16'hFDB4;

  localparam int SYS_ACC_BIT = 0;

  // mode control bit positions
  localparam int B_PRG = 0;
  localparam int B_ERS = 1;
  localparam int B_PVF = 2;
  localparam int B_EVF = 3;
  localparam int B_PSU = 4;
  localparam int B_ESU = 5;
  localparam int B_SWE = 6;
  localparam int B_PIN = 7;

  typedef enum logic [MODE_W-1:0] {
    M_IDLE = 5'b00001,
    M_PROG = 5'b00010,
    M_ERS  = 5'b00100,
    M_PVF  = 5'b01000,
    M_EVF  = 5'b10000
  } mode_e;
endpackage

// File: rtl/flash_ilk_decode.sv
module flash_ilk_decode
  import flash_ilk_pkg::*;
(
  input  logic [AW-1:0]      addr,
  input  logic               we,
  input  logic               acc_en,
  input  logic               flash_en,
  input  logic               pin,
  output logic               sel_ctl,
  output logic               sel_stat,
  output logic [NUM_AUX-1:0] sel_aux,
  output logic               sel_sys,
  output logic               sel_emu,
  output logic               gate_open,
  output logic               gated_hit,
  output logic               ctl_wr,
  output logic [NUM_AUX-1:0] aux_wr,
  output logic               sys_wr,
  output logic               emu_wr
);
  logic gated_wr_ok;

  always_comb begin
    sel_ctl  = (addr == A_CTL);
    sel_stat = (addr == A_STAT);
    sel_sys  = (addr == A_SYS);
    sel_emu  = (addr == A_EMU);
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_AUX; gi++) begin : g_aux_sel
      assign sel_aux[gi] = (addr == (A_AUX0 + AW'(gi)));
      assign aux_wr[gi]  = gated_wr_ok & sel_aux[gi];
    end
  endgenerate

  always_comb begin
    gate_open   = acc_en & flash_en;
    gated_hit   = sel_ctl | sel_stat | (|sel_aux);
    gated_wr_ok = we & gate_open & pin;
    ctl_wr      = gated_wr_ok & sel_ctl;
    sys_wr      = we & sel_sys;
    emu_wr      = we & sel_emu;
  end
endmodule

// File: rtl/flash_ilk_mode.sv
module flash_ilk_mode
  import flash_ilk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin,
  input  logic              stby,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     ctl_rd,
  output logic [MODE_W-1:0] mode_code,
  output logic              swe
);
  logic [B_PIN-1:0] st_q, st_d;
  logic prog_act, ers_act;
  logic swe_n, psu_n, esu_n;

  always_comb begin
    prog_act = st_q[B_PSU] | st_q[B_PRG];
    ers_act  = st_q[B_ESU] | st_q[B_ERS];
    swe_n    = wdata[B_SWE];
    psu_n    = wdata[B_PSU] & swe_n & st_q[B_SWE] & ~ers_act;
    esu_n    = wdata[B_ESU] & swe_n & st_q[B_SWE] & ~prog_act & ~psu_n;
    st_d     = st_q;
    if (stby || !pin) begin
      st_d = '0;
    end else if (wr) begin
      st_d        = '0;
      st_d[B_SWE] = swe_n;
      st_d[B_PSU] = psu_n;
      st_d[B_ESU] = esu_n;
      st_d[B_PRG] = wdata[B_PRG] & psu_n & st_q[B_PSU];
      st_d[B_ERS] = wdata[B_ERS] & esu_n & st_q[B_ESU];
      st_d[B_PVF] = wdata[B_PVF] & swe_n & st_q[B_SWE];
      st_d[B_EVF] = wdata[B_EVF] & swe_n & st_q[B_SWE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  always_comb begin
    ctl_rd = {pin, st_q};
    swe    = st_q[B_SWE];
    if (!pin)               mode_code = M_IDLE;
    else if (st_q[B_PRG])   mode_code = M_PROG;
    else if (st_q[B_ERS])   mode_code = M_ERS;
    else if (st_q[B_PVF])   mode_code = M_PVF;
    else if (st_q[B_EVF])   mode_code = M_EVF;
    else                    mode_code = M_IDLE;
  end

  a_r6_prog_needs_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[B_PRG]) |-> $past(st_q[B_PSU]));
  a_r7_erase_needs_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[B_ERS]) |-> $past(st_q[B_ESU]));
  a_r8_verify_needs_swe: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_q[B_PVF]) || $rose(st_q[B_EVF])) |-> $past(st_q[B_SWE]));
  a_r9_paths_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((st_q[B_PSU] | st_q[B_PRG]) && (st_q[B_ESU] | st_q[B_ERS])));
  a_r10_swe_clear_drops_all: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q[B_SWE] |-> (st_q[B_ESU:0] == '0));
  a_r11_code_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_code) == 1);
  a_r12_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> (st_q == '0));
endmodule

// File: rtl/flash_ilk_areg.sv
module flash_ilk_areg
  import flash_ilk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_ok,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (!hold_ok)  q_d = '0;
    else if (wr)   q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;

  a_r5_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ok |=> (q_r == '0));
endmodule

// File: rtl/flash_ctl_interlock.sv
module flash_ctl_interlock
  import flash_ilk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              prog_pin,
  input  logic              flash_en,
  input  logic [15:0]       bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [4:0]        mode_code,
  output logic [15:0]       erase_sel,
  output logic [7:0]        pwr_cfg
);
  logic [1:0]         rst_sync_q;
  logic               rst_i_n;
  logic [DW-1:0]      sys_q, sys_d, emu_q, emu_d;
  logic               sel_ctl, sel_stat, sel_sys, sel_emu;
  logic [NUM_AUX-1:0] sel_aux, aux_wr;
  logic               gate_open, gated_hit, ctl_wr, sys_wr, emu_wr;
  logic [DW-1:0]      ctl_rd;
  logic               swe;
  logic [DW-1:0]      aux_q [NUM_AUX];
  logic               aux_hold;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  flash_ilk_decode u_dec (
    .addr(bus_addr), .we(bus_we), .acc_en(sys_q[SYS_ACC_BIT]),
    .flash_en(flash_en), .pin(prog_pin),
    .sel_ctl(sel_ctl), .sel_stat(sel_stat), .sel_aux(sel_aux),
    .sel_sys(sel_sys), .sel_emu(sel_emu), .gate_open(gate_open),
    .gated_hit(gated_hit), .ctl_wr(ctl_wr), .aux_wr(aux_wr),
    .sys_wr(sys_wr), .emu_wr(emu_wr)
  );

  flash_ilk_mode u_mode (
    .clk(clk), .rst_n(rst_i_n), .pin(prog_pin), .stby(hw_stby | sw_stby),
    .wr(ctl_wr), .wdata(bus_wdata), .ctl_rd(ctl_rd),
    .mode_code(mode_code), .swe(swe)
  );

  assign aux_hold = prog_pin & swe;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_AUX; gi++) begin : g_aux
      flash_ilk_areg u_areg (
        .clk(clk), .rst_n(rst_i_n), .hold_ok(aux_hold),
        .wr(aux_wr[gi]), .wdata(bus_wdata), .q(aux_q[gi])
      );
    end
  endgenerate

  always_comb begin
    sys_d = sys_wr ? bus_wdata : sys_q;
    emu_d = emu_wr ? bus_wdata : emu_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sys_q <= '0;
      emu_q <= '0;
    end else begin
      sys_q <= sys_d;
      emu_q <= emu_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_sys)                   bus_rdata = sys_q;
    else if (sel_emu)              bus_rdata = emu_q;
    else if (gate_open) begin
      if (sel_ctl)                 bus_rdata = ctl_rd;
      else if (sel_stat)           bus_rdata = {{(DW-MODE_W){1'b0}}, mode_code};
      else begin
        for (int i = 0; i < NUM_AUX; i++)
          if (sel_aux[i])          bus_rdata = aux_q[i];
      end
    end
  end

  assign erase_sel = {aux_q[1], aux_q[0]};
  assign pwr_cfg   = aux_q[2];

  a_r3_gated_read_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (gated_hit && !gate_open) |-> (bus_rdata == '0));
  a_r4_pin_low_blocks: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!prog_pin && bus_we && sel_ctl) |=> (ctl_rd[B_PIN-1:0] == '0));
  a_r10_pin_low_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    !prog_pin |-> (mode_code == M_IDLE));
endmodule

// File: tb/flash_ctl_interlock_tb.sv
module flash_ctl_interlock_tb;
  logic clk = 0;
  logic rst_n, hw_stby, sw_stby, prog_pin, flash_en, bus_we;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, pwr_cfg;
  logic [4:0]  mode_code;
  logic [15:0] erase_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int kind; logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];
  event chk_ev;

  always #2.5 clk = ~clk;

  flash_ctl_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .prog_pin(prog_pin), .flash_en(flash_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode_code(mode_code), .erase_sel(erase_sel), .pwr_cfg(pwr_cfg)
  );

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = {8'h00, bus_rdata};
          1: act = {11'h0, mode_code};
          2: act = erase_sel;
          default: act = {8'h00, pwr_cfg};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push_chk(input int kind, input logic [15:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    #1 -> chk_ev;
    #0.5;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    push_chk(0, {8'h00, exp}, tag);
  endtask

  task automatic md(input logic [4:0] exp, input string tag);
    @(negedge clk);
    push_chk(1, {11'h0, exp}, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; hw_stby = 0; sw_stby = 0; prog_pin = 1; flash_en = 1;
    bus_we = 0; bus_addr = 16'h0; bus_wdata = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    rd(16'hFFA8, 8'h00, "R3 gated read with access bit clear");
    md(5'b00001, "R1 idle after reset");
    wr(16'hFDB4, 8'h01);
    rd(16'hFDB4, 8'h01, "R2 system register readback");
    wr(16'hFEDB, 8'h5A);
    rd(16'hFEDB, 8'h5A, "R2 emulation register readback");
    rd(16'hFFA8, 8'h80, "R1 pin bit in reset value");

    wr(16'hFFAA, 8'h33);
    rd(16'hFFAA, 8'h00, "R5 block write with swe clear");
    wr(16'hFFA8, 8'h10);
    rd(16'hFFA8, 8'h80, "R6 setup without prior swe");
    wr(16'hFFA8, 8'h40);
    rd(16'hFFA8, 8'hC0, "R6 swe set");
    wr(16'hFFA8, 8'h41);
    rd(16'hFFA8, 8'hC0, "R6 program without setup");
    wr(16'hFFA8, 8'h50);
    wr(16'hFFA8, 8'h51);
    rd(16'hFFA8, 8'hD1, "R6 program entered");
    md(5'b00010, "R11 program code");
    rd(16'hFFA9, 8'h02, "R11 status reflects program");
    wr(16'hFFA9, 8'hFF);
    rd(16'hFFA9, 8'h02, "R11 status ignores write");
    wr(16'hFFA8, 8'h71);
    rd(16'hFFA8, 8'hD1, "R9 erase setup blocked by program");

    wr(16'hFFAA, 8'hA5);
    wr(16'hFFAB, 8'h3C);
    wr(16'hFFAC, 8'h07);
    @(negedge clk); push_chk(2, 16'h3CA5, "R5 erase select written");
    @(negedge clk); push_chk(3, 16'h0007, "R5 power written");

    wr(16'hFDB4, 8'h00);
    rd(16'hFFA8, 8'h00, "R3 gated read after access cleared");
    wr(16'hFFAA, 8'h00);
    wr(16'hFDB4, 8'h01);
    @(negedge clk); push_chk(2, 16'h3CA5, "R3 write ignored with access clear");
    flash_en = 0;
    rd(16'hFFA9, 8'h00, "R3 flash disabled read");
    wr(16'hFFAC, 8'hFF);
    flash_en = 1;
    @(negedge clk); push_chk(3, 16'h0007, "R3 write ignored with flash disabled");

    wr(16'hFFA8, 8'h11);
    rd(16'hFFA8, 8'h80, "R10 swe clear drops mode bits");
    md(5'b00001, "R10 idle after swe clear");
    @(negedge clk); push_chk(2, 16'h0000, "R5 erase select cleared");
    @(negedge clk); push_chk(3, 16'h0000, "R5 power cleared");

    wr(16'hFFA8, 8'h40);
    wr(16'hFFA8, 8'h60);
    wr(16'hFFA8, 8'h62);
    rd(16'hFFA8, 8'hE2, "R7 erase entered");
    md(5'b00100, "R7 erase code");
    wr(16'hFFA8, 8'h72);
    rd(16'hFFA8, 8'hE2, "R9 program setup blocked by erase");

    wr(16'hFFA8, 8'h40);
    wr(16'hFFA8, 8'h44);
    md(5'b01000, "R8 program-verify code");
    wr(16'hFFA8, 8'h48);
    md(5'b10000, "R8 erase-verify code");
    wr(16'hFFA8, 8'h00);
    wr(16'hFFA8, 8'h08);
    rd(16'hFFA8, 8'h80, "R8 verify without swe");

    wr(16'hFFA8, 8'h40);
    wr(16'hFFA8, 8'h70);
    rd(16'hFFA8, 8'hD0, "R9 both setups keep program");

    wr(16'hFFA8, 8'h51);
    @(negedge clk);
    prog_pin = 0;
    push_chk(1, 16'h0001, "R10 idle at once on pin low");
    rd(16'hFFA8, 8'h00, "R10 mode bits cleared by pin low");
    wr(16'hFFA8, 8'h40);
    rd(16'hFFA8, 8'h00, "R4 write ignored with pin low");
    prog_pin = 1;
    rd(16'hFFA8, 8'h80, "R1 pin bit follows pin");

    wr(16'hFFA8, 8'h40);
    wr(16'hFFA8, 8'h50);
    @(negedge clk); sw_stby = 1;
    @(negedge clk); sw_stby = 0;
    rd(16'hFFA8, 8'h80, "R12 software standby clears");
    wr(16'hFFA8, 8'h40);
    @(negedge clk); hw_stby = 1;
    @(negedge clk); hw_stby = 0;
    rd(16'hFFA8, 8'h80, "R12 hardware standby clears");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule